// File: doc/BRIEF.md
# Interleaving Frame Bank Buffer Controller

This block takes an 8-bit luminance stream from a video decoder and the pixel clock it runs on, and feeds a compression engine that runs on a slower, unrelated clock. The two sides share a dual-port frame memory. The memory sits outside the block and has one write port and one read port. The memory is split into four banks, and each bank holds one square frame. The write side captures one whole frame into the next bank after every qualifying vertical sync. The read side plays frames out without pause. When it finishes a bank and the following bank is not yet complete, it plays the same bank again. This absorbs the small rate difference between a slightly faster reader and the writer.

The reader does not fetch pixels in raster order. The frame is cut into square subframes. The first pixel of every subframe leaves first, in raster order of the subframes. Then the second pixel of every subframe leaves, and so on. This order comes from a fixed rewiring of a linear counter onto the memory address. Before streaming starts, the reader pulses the engine reset, idles, waits for the first bank to be complete, and pulses the engine start. A source select input chooses whether the buffer or an external preloaded image store drives the shared pixel bus. The two output enables are never both high.

Top module: `frame_ring_ctrl`

## Requirements
- R1: Every memory write places the pixel at address bank*FRAME_DIM^2 + index. The bank sits in the top BANK_BITS address bits and the pixel index (0..FRAME_DIM^2-1, in arrival order) in the low bits. The written data equals the luminance input sampled one write clock earlier.
- R2: The write side starts a frame only after a write clock in which vertical sync (active low) is low and the field input is high. It then stores exactly FRAME_DIM^2 pixels and returns to waiting, and pixels offered while it waits are not stored. Successive frames use banks 0,1,2,3,0,…
- R3: A pixel is stored only when the valid input and the active-video input are both high on the same write clock.
- R4: After read reset, eng_rst is high for exactly one read clock. eng_start is high for exactly one read clock and rises no sooner than DELAY_CYCLES+1 read clocks after eng_rst rose, and only after bank 0 is completely written. The first read address appears in the read clock that follows the eng_start cycle.
- R5: The read side starts on bank 0 and reads each frame wholly from one bank. At a frame boundary it moves to the next bank (mod 4) only if that bank is complete and not being written. Otherwise it replays the same bank. Its bank never changes in mid-frame.
- R6: Within a frame, read number n (0..FRAME_DIM^2-1) gets address row*FRAME_DIM+col. Here T=log2(FRAME_DIM/SUB_DIM) and S=log2(SUB_DIM). n[T-1:0] is the subframe column, n[2T-1:T] the subframe row, n[2T+S-1:2T] the column inside the subframe, and the top S bits the row inside the subframe. row = subframe_row*SUB_DIM + inner_row and col = subframe_col*SUB_DIM + inner_col.
- R7: buf_oe equals pix_valid AND NOT src_sel, and store_oe equals pix_valid AND src_sel, with src_sel sampled on the read clock edge that produced the address. The two enables are never high together.
- R8: Once the first read address is issued, pix_valid stays high on every read clock.
- R9: While reset is held, all write and read outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Decoder pixel clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| vd_luma | input | PIX_W | Luminance sample |
| vd_valid | input | 1 | Sample valid |
| vd_active | input | 1 | Active video area |
| vd_vsync_n | input | 1 | Vertical sync, active low |
| vd_field | input | 1 | Field indicator, high for the capture field |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | ADDR_W | Memory write address {bank, index} |
| mem_wdata | output | PIX_W | Memory write data |
| rd_clk | input | 1 | Engine clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| src_sel | input | 1 | 0 selects the buffer, 1 the external image store |
| mem_raddr | output | ADDR_W | Read address {bank, interleaved pixel} |
| pix_valid | output | 1 | Read address valid this cycle |
| buf_oe | output | 1 | Buffer output enable |
| store_oe | output | 1 | Image store output enable |
| eng_rst | output | 1 | Engine reset pulse |
| eng_start | output | 1 | Engine start pulse |

## Verification
The risky coincidence is a read frame boundary that lands while the writer is closing one bank and opening the next. The bank decision then rests on a bank index that has just crossed clock domains. The bench runs the writer on a 6 ns clock with irregular pixel gaps and the reader on a 4 ns clock, so boundaries of both sides drift across each other over ten frames. At each read frame start it judges the chosen bank against its own record of which banks are complete and which one is being filled. A second overlap is a source-select change that lands in the same cycle as a bank change. The select toggles on a period prime to the frame length, and the enables are compared on every cycle.

// File: rtl/frame_ring_pkg.sv
package frame_ring_pkg;
  typedef enum logic [0:0] {WR_IDLE, WR_FILL} wr_state_t;
  typedef enum logic [2:0] {RD_RESET, RD_DELAY, RD_WAIT, RD_START, RD_STREAM} rd_state_t;
endpackage

// File: rtl/fr_write_side.sv
module fr_write_side
  import frame_ring_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int PIX_BITS  = 14,
  parameter int BANK_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [PIX_W-1:0]              luma,
  input  logic                          dvalid,
  input  logic                          active,
  input  logic                          vsync_n,
  input  logic                          field,
  output logic                          we,
  output logic [PIX_BITS+BANK_BITS-1:0] waddr,
  output logic [PIX_W-1:0]              wdata,
  output logic [BANK_BITS-1:0]          bank_gray
);
  localparam logic [PIX_BITS-1:0] LAST_PIX = '1;

  wr_state_t            state;
  logic [PIX_BITS-1:0]  cnt;
  logic [BANK_BITS-1:0] bank;
  logic [BANK_BITS-1:0] bank_nxt;

  assign bank_nxt = bank + 1'b1;

  // R2: arm on sync, capture one frame, advance bank; R3: qualified samples only
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WR_IDLE;
      cnt       <= '0;
      bank      <= '0;
      bank_gray <= '0;
      we        <= 1'b0;
      waddr     <= '0;
      wdata     <= '0;
    end else begin
      we <= 1'b0;
      case (state)
        WR_IDLE: begin
          if (!vsync_n && field) begin
            state <= WR_FILL;
            cnt   <= '0;
          end
        end
        WR_FILL: begin
          if (dvalid && active) begin
            we    <= 1'b1;
            waddr <= {bank, cnt};
            wdata <= luma;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_PIX) begin
              state     <= WR_IDLE;
              bank      <= bank_nxt;
              bank_gray <= bank_nxt ^ (bank_nxt >> 1);
            end
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fr_gray_sync.sv
module fr_gray_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else     stage <= {stage[STAGES-2:0], gray_in};
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(stage[STAGES-1] >> i);
  end
endmodule

// File: rtl/fr_addr_map.sv
module fr_addr_map #(
  parameter int FRAME_DIM = 128,
  parameter int SUB_DIM   = 4
) (
  input  logic [2*$clog2(FRAME_DIM)-1:0] seq,
  output logic [2*$clog2(FRAME_DIM)-1:0] pix_addr
);
  localparam int FB = $clog2(FRAME_DIM);
  localparam int SB = $clog2(SUB_DIM);
  localparam int TB = FB - SB;
  localparam int PB = 2 * FB;

  logic [TB-1:0] tile_col, tile_row;
  logic [SB-1:0] in_col, in_row;

  // R6: pure rewiring of the linear counter
  assign tile_col = seq[TB-1:0];
  assign tile_row = seq[2*TB-1:TB];
  assign in_col   = seq[2*TB+SB-1:2*TB];
  assign in_row   = seq[PB-1:2*TB+SB];
  assign pix_addr = {tile_row, in_row, tile_col, in_col};
endmodule

// File: rtl/fr_read_side.sv
module fr_read_side
  import frame_ring_pkg::*;
#(
  parameter int FRAME_DIM    = 128,
  parameter int SUB_DIM      = 4,
  parameter int BANK_BITS    = 2,
  parameter int DELAY_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  src_sel,
  input  logic [BANK_BITS-1:0]  wr_bank,
  output logic [2*$clog2(FRAME_DIM)+BANK_BITS-1:0] raddr,
  output logic                  pix_valid,
  output logic                  buf_oe,
  output logic                  store_oe,
  output logic                  eng_rst,
  output logic                  eng_start
);
  localparam int PB    = 2 * $clog2(FRAME_DIM);
  localparam int DLY_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [PB-1:0]    LAST_PIX = '1;
  localparam logic [DLY_W-1:0] DLY_END  = DLY_W'(DELAY_CYCLES - 1);

  rd_state_t            state;
  logic [DLY_W-1:0]     dly;
  logic [PB-1:0]        seq;
  logic [PB-1:0]        pix_addr;
  logic [BANK_BITS-1:0] bank;
  logic [BANK_BITS-1:0] bank_nxt;
  logic                 emit;

  fr_addr_map #(.FRAME_DIM(FRAME_DIM), .SUB_DIM(SUB_DIM)) i_map (
    .seq(seq), .pix_addr(pix_addr)
  );

  assign bank_nxt = bank + 1'b1;
  assign emit     = (state == RD_START) || (state == RD_STREAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_RESET;
      dly       <= '0;
      seq       <= '0;
      bank      <= '0;
      raddr     <= '0;
      pix_valid <= 1'b0;
      buf_oe    <= 1'b0;
      store_oe  <= 1'b0;
      eng_rst   <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_rst   <= 1'b0;
      eng_start <= 1'b0;
      pix_valid <= emit;                 // R8
      buf_oe    <= emit && !src_sel;     // R7
      store_oe  <= emit && src_sel;
      case (state)
        RD_RESET: begin                  // R4
          eng_rst <= 1'b1;
          dly     <= '0;
          state   <= RD_DELAY;
        end
        RD_DELAY: begin
          if (dly == DLY_END) state <= RD_WAIT;
          else                dly   <= dly + 1'b1;
        end
        RD_WAIT: begin
          if (wr_bank != '0) begin       // bank 0 complete
            eng_start <= 1'b1;
            state     <= RD_START;
          end
        end
        RD_START:  state <= RD_STREAM;
        RD_STREAM: state <= RD_STREAM;
        default:   state <= RD_RESET;
      endcase
      if (emit) begin
        raddr <= {bank, pix_addr};
        seq   <= seq + 1'b1;
        // R5: advance only into a bank the writer has left
        if (seq == LAST_PIX && bank_nxt != wr_bank) bank <= bank_nxt;
      end
    end
  end
endmodule

// File: rtl/frame_ring_ctrl.sv
module frame_ring_ctrl #(
  parameter int PIX_W        = 8,
  parameter int FRAME_DIM    = 128,
  parameter int SUB_DIM      = 4,
  parameter int BANK_BITS    = 2,
  parameter int DELAY_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                                    wr_clk,
  input  logic                                    wr_rst,
  input  logic [PIX_W-1:0]                        vd_luma,
  input  logic                                    vd_valid,
  input  logic                                    vd_active,
  input  logic                                    vd_vsync_n,
  input  logic                                    vd_field,
  output logic                                    mem_we,
  output logic [2*$clog2(FRAME_DIM)+BANK_BITS-1:0] mem_waddr,
  output logic [PIX_W-1:0]                        mem_wdata,
  input  logic                                    rd_clk,
  input  logic                                    rd_rst,
  input  logic                                    src_sel,
  output logic [2*$clog2(FRAME_DIM)+BANK_BITS-1:0] mem_raddr,
  output logic                                    pix_valid,
  output logic                                    buf_oe,
  output logic                                    store_oe,
  output logic                                    eng_rst,
  output logic                                    eng_start
);
  localparam int PIX_BITS = 2 * $clog2(FRAME_DIM);
  localparam int ADDR_W   = PIX_BITS + BANK_BITS;

  logic [BANK_BITS-1:0] wr_gray;
  logic [BANK_BITS-1:0] wr_bank_rd;

  fr_write_side #(.PIX_W(PIX_W), .PIX_BITS(PIX_BITS), .BANK_BITS(BANK_BITS)) i_wr (
    .clk(wr_clk), .rst(wr_rst), .luma(vd_luma), .dvalid(vd_valid),
    .active(vd_active), .vsync_n(vd_vsync_n), .field(vd_field),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata), .bank_gray(wr_gray)
  );

  fr_gray_sync #(.W(BANK_BITS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wr_gray), .bin_out(wr_bank_rd)
  );

  fr_read_side #(
    .FRAME_DIM(FRAME_DIM), .SUB_DIM(SUB_DIM),
    .BANK_BITS(BANK_BITS), .DELAY_CYCLES(DELAY_CYCLES)
  ) i_rd (
    .clk(rd_clk), .rst(rd_rst), .src_sel(src_sel), .wr_bank(wr_bank_rd),
    .raddr(mem_raddr), .pix_valid(pix_valid), .buf_oe(buf_oe),
    .store_oe(store_oe), .eng_rst(eng_rst), .eng_start(eng_start)
  );
endmodule

// File: rtl/frame_ring_ctrl_chk.sv
module frame_ring_ctrl_chk #(
  parameter int PIX_W     = 8,
  parameter int PIX_BITS  = 14,
  parameter int BANK_BITS = 2,
  parameter int ADDR_W    = 16
) (
  input logic              wr_clk,
  input logic              wr_rst,
  input logic [PIX_W-1:0]  vd_luma,
  input logic              vd_valid,
  input logic              vd_active,
  input logic              mem_we,
  input logic [PIX_W-1:0]  mem_wdata,
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              src_sel,
  input logic [ADDR_W-1:0] mem_raddr,
  input logic              pix_valid,
  input logic              buf_oe,
  input logic              store_oe,
  input logic              eng_rst,
  input logic              eng_start
);
  logic [BANK_BITS-1:0] rd_bank, bank_q;
  assign rd_bank = mem_raddr[ADDR_W-1:PIX_BITS];
  always_ff @(posedge rd_clk) bank_q <= rd_bank;

  p_we_qualified_r3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    mem_we |-> $past(vd_valid && vd_active));
  p_wdata_r1: assert property (@(posedge wr_clk) disable iff (wr_rst)
    mem_we |-> (mem_wdata == $past(vd_luma)));
  p_rst_pulse_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    eng_rst |=> !eng_rst);
  p_start_pulse_r4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    eng_start |=> (!eng_start && pix_valid));
  p_oe_exclusive_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !(buf_oe && store_oe));
  p_oe_select_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    pix_valid |-> (buf_oe == !$past(src_sel)));
  p_stream_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    pix_valid |=> pix_valid);
  p_bank_step_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (pix_valid && $past(pix_valid)) |->
      (rd_bank == bank_q || rd_bank == BANK_BITS'(bank_q + 1'b1)));
  p_bank_at_frame_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (pix_valid && $past(pix_valid) && rd_bank != bank_q) |->
      (mem_raddr[PIX_BITS-1:0] == '0));
endmodule

bind frame_ring_ctrl frame_ring_ctrl_chk #(
  .PIX_W(PIX_W), .PIX_BITS(PIX_BITS), .BANK_BITS(BANK_BITS), .ADDR_W(ADDR_W)
) i_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .vd_luma(vd_luma), .vd_valid(vd_valid),
  .vd_active(vd_active), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .src_sel(src_sel), .mem_raddr(mem_raddr),
  .pix_valid(pix_valid), .buf_oe(buf_oe), .store_oe(store_oe),
  .eng_rst(eng_rst), .eng_start(eng_start)
);

// File: tb/test_frame_ring_ctrl.sv
module test_frame_ring_ctrl;
  localparam int FD = 8, SD = 2, NPIX = FD * FD, NFR = 10;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic [7:0] vd_luma = 0;
  logic vd_valid = 0, vd_active = 0, vd_vsync_n = 1, vd_field = 0, src_sel = 0;
  logic mem_we, pix_valid, buf_oe, store_oe, eng_rst, eng_start;
  logic [7:0] mem_waddr, mem_raddr, mem_wdata;

  int checks = 0, failures = 0;
  bit done = 0;
  int wr_frames = 0, wr_idx = 0;
  bit [3:0] bank_done = '0;
  bit writing = 0;
  logic [1:0] writing_bank = 0;
  bit saw_wrap = 0;
  int rd_cyc = 0, rst_cyc = 0, n_rst = 0, n_start = 0, rd_pos = 0, frames_rd = 0;
  int replays = 0, advances = 0;
  bit start_prev = 0, streaming = 0, sel_seen = 0;
  logic [1:0] cur_bank = 0;

  always #3 wr_clk = ~wr_clk;
  always #2 rd_clk = ~rd_clk;   // 250 MHz

  frame_ring_ctrl #(.PIX_W(8), .FRAME_DIM(FD), .SUB_DIM(SD), .BANK_BITS(2),
                    .DELAY_CYCLES(4), .SYNC_STAGES(2)) i_frame_ring_ctrl (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .vd_luma(vd_luma), .vd_valid(vd_valid),
    .vd_active(vd_active), .vd_vsync_n(vd_vsync_n), .vd_field(vd_field),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .src_sel(src_sel), .mem_raddr(mem_raddr),
    .pix_valid(pix_valid), .buf_oe(buf_oe), .store_oe(store_oe),
    .eng_rst(eng_rst), .eng_start(eng_start)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pix(input int f, input int i);
    return 8'(((f % 2) * 64) + i);
  endfunction

  function automatic int exp_raddr(input int n);
    int tc = n % 4, tr = (n / 4) % 4, ic = (n / 16) % 2, ir = (n / 32) % 2;
    return (tr * SD + ir) * FD + tc * SD + ic;
  endfunction

  // write monitor: R1 R2 R3
  always @(negedge wr_clk) begin
    if (!wr_rst && mem_we) begin
      if (mem_wdata == 8'hEE)
        check(0, "R2 pixel stored while waiting", mem_wdata, 0);
      else if (mem_wdata == 8'hDD)
        check(0, "R3 unqualified pixel stored", mem_wdata, 0);
      else
        check(mem_waddr == {wr_frames[1:0], 6'(wr_idx)} && mem_wdata == exp_pix(wr_frames, wr_idx),
              "R1 write address/data", {mem_waddr, mem_wdata},
              {wr_frames[1:0], 6'(wr_idx), exp_pix(wr_frames, wr_idx)});
      if (wr_idx == 0) begin
        if (wr_frames > 0 && wr_frames % 4 == 0) saw_wrap = 1;
        bank_done[wr_frames % 4] = 0;
        writing = 1;
        writing_bank = 2'(wr_frames % 4);
      end
      wr_idx++;
      if (wr_idx == NPIX) begin
        bank_done[wr_frames % 4] = 1;
        writing = 0;
        wr_idx = 0;
        wr_frames++;
      end
    end
  end

  // read monitor: R4 R5 R6 R7 R8
  always @(negedge rd_clk) begin
    if (!rd_rst) begin
      logic [1:0] b, nb;
      rd_cyc++;
      if (eng_rst) begin n_rst++; rst_cyc = rd_cyc; end
      if (start_prev) check(pix_valid, "R4 first address follows start", pix_valid, 1);
      if (eng_start) begin
        n_start++;
        check(bank_done[0], "R4 start before bank 0 complete", bank_done[0], 1);
        check(rd_cyc - rst_cyc >= 5, "R4 reset-to-start gap", rd_cyc - rst_cyc, 5);
      end
      start_prev = eng_start;
      if (streaming) check(pix_valid, "R8 stream gap", pix_valid, 1);
      check(buf_oe == (pix_valid && !sel_seen) && store_oe == (pix_valid && sel_seen),
            "R7 output enables", {buf_oe, store_oe}, {pix_valid && !sel_seen, pix_valid && sel_seen});
      if (pix_valid) begin
        streaming = 1;
        b = mem_raddr[7:6];
        check(int'(mem_raddr[5:0]) == exp_raddr(rd_pos), "R6 interleaved address",
              mem_raddr[5:0], exp_raddr(rd_pos));
        if (rd_pos == 0) begin
          nb = cur_bank + 2'd1;
          if (frames_rd == 0) check(b == 0, "R5 first bank", b, 0);
          else begin
            check(b == cur_bank || b == nb, "R5 bank step", b, nb);
            if (b == cur_bank) replays++; else advances++;
          end
          check(bank_done[b] && !(writing && writing_bank == b), "R5 bank not complete",
                b, writing_bank);
          cur_bank = b;
        end else
          check(b == cur_bank, "R5 bank changed in frame", b, cur_bank);
        rd_pos = (rd_pos + 1) % NPIX;
        if (rd_pos == 0) frames_rd++;
      end
    end
    sel_seen = src_sel;
  end

  task automatic drive_frame(input int f);
    @(negedge wr_clk); vd_vsync_n = 0; vd_field = 0; vd_valid = 1; vd_active = 1; vd_luma = 8'hEE;
    @(negedge wr_clk);
    @(negedge wr_clk); vd_field = 1; vd_valid = 0; vd_active = 0;
    @(negedge wr_clk); vd_vsync_n = 1; vd_field = 0;
    for (int i = 0; i < NPIX; i++) begin
      if (i % 3 == 1) begin
        vd_valid = 1; vd_active = 0; vd_luma = 8'hDD; @(negedge wr_clk);
        vd_valid = 0; vd_active = 1; @(negedge wr_clk);
      end
      vd_valid = 1; vd_active = 1; vd_luma = exp_pix(f, i); @(negedge wr_clk);
    end
    vd_luma = 8'hEE; repeat (6) @(negedge wr_clk);
    vd_valid = 0; vd_active = 0;
    check(wr_frames == f + 1, "R2 frame length/stop", wr_frames, f + 1);
  endtask

  initial begin
    forever begin
      repeat (37) @(posedge rd_clk);
      #1 src_sel = ~src_sel;
      if (done) break;
    end
  end

  initial begin
    repeat (200000) @(posedge rd_clk);
    if (!done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge rd_clk);
    check(!mem_we && !pix_valid && !buf_oe && !store_oe && !eng_rst && !eng_start,
          "R9 outputs in reset", {mem_we, pix_valid, buf_oe, store_oe, eng_rst, eng_start}, 0);
    wr_rst = 0; rd_rst = 0;
    for (int f = 0; f < NFR; f++) drive_frame(f);
    repeat (200) @(negedge rd_clk);
    check(n_rst == 1, "R4 reset pulse count", n_rst, 1);
    check(n_start == 1, "R4 start pulse count", n_start, 1);
    check(replays > 0, "R5 replay seen", replays, 1);
    check(advances >= 3, "R5 advances seen", advances, 3);
    check(saw_wrap, "R2 bank wrap", saw_wrap, 1);
    check(frames_rd > NFR, "R8 frames streamed", frames_rd, NFR);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule